// File: doc/BRIEF.md
# Descriptor Ring Index Tracker

This block keeps the per-channel bookkeeping of a circular descriptor table that is shared between host software and a DMA engine. Software programs a channel control word (an enable bit and a 4-bit ring size code), the table's base address, and a producer index. That index is called the kick index. It points one entry past the last descriptor that software has made valid. The DMA engine sends one pulse on `desc_done` each time it retires a descriptor. The block then moves the consumer index (the completion index) forward by one and wraps it at the ring size.

From these registers the block derives three outputs. The first is the byte address of the next descriptor to fetch: the base plus sixteen bytes per entry. The second is the number of outstanding descriptors. The third is an idle flag. The engine uses the fetch address and the pending count. Software reads back both indices to reclaim or refill entries.

A build-time parameter selects the receive flavour. In that flavour software must post descriptors in groups of four. A kick index that is not a multiple of four is dropped, and the block flags an error for one cycle.

Top module: `desc_ring_tracker`

## Requirements
- R1: After reset the channel is disabled, the size code is 0, and the base, both indices, the pending count, the fetch address, `idle` and `kick_err` are all zero.
- R2: A control write (`cfg_we`) takes the enable from `cfg_wdata` bit 0 and the size code from bits 4:1. It also clears both the kick index and the completion index to zero.
- R3: Size codes 0 to 8 select 32, 64, 128, … 8192 entries (32 shifted left by the code). Codes 9 to 15 select 8192 entries. Both indices wrap at the selected size.
- R4: A base write stores the written address with its low 11 bits forced to zero, so the table is always 2 KB aligned.
- R5: In the transmit flavour, a kick write stores the written value reduced modulo the ring size, and `kick_err` stays low.
- R6: In the receive flavour, a kick write whose bits 1:0 are zero is stored as in R5. A kick write with either of those bits set leaves the kick index unchanged and drives `kick_err` high for exactly the following cycle.
- R7: A `desc_done` pulse advances the completion index by one, modulo the ring size. This happens only when the channel is enabled and the completion index differs from the kick index. Otherwise the pulse has no effect.
- R8: `pending` equals (kick index − completion index) modulo the ring size.
- R9: `idle` is high exactly when the channel is enabled and the completion index equals the kick index.
- R10: `fetch_addr` equals the base address plus 16 times the completion index.
- R11: When a control write arrives in the same cycle as a kick write or a `desc_done` pulse, the control write wins. Both indices end at zero, and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 5 | Bit 0 enable, bits 4:1 ring size code |
| base_we | input | 1 | Base address write strobe |
| base_wdata | input | ADDR_W | Base address to store |
| kick_we | input | 1 | Kick index write strobe |
| kick_wdata | input | IDX_W | New kick index |
| desc_done | input | 1 | One-cycle pulse per descriptor retired by the engine |
| ring_en | output | 1 | Channel enable readback |
| size_code | output | 4 | Ring size code readback |
| base_addr | output | ADDR_W | Stored base, low 11 bits zero |
| kick_idx | output | IDX_W | Current kick index |
| comp_idx | output | IDX_W | Current completion index |
| pending | output | IDX_W | Outstanding descriptor count |
| idle | output | 1 | Enabled and nothing outstanding |
| kick_err | output | 1 | One-cycle flag for a rejected kick |
| fetch_addr | output | ADDR_W | Address of the next descriptor |

## Verification
The bench builds two copies at the default 13-bit index and 32-bit address widths. One copy uses the receive flavour and the other the transmit flavour. Both share the same stimulus, so every kick value shows side by side whether it is rejected or accepted. With full-width indices, every size code can be reached, including the clamped codes above 8. The tests cover wrap-around at the 32-entry ring and near the 8192-entry top, along with random runs that change the size code while descriptors are outstanding.

// File: rtl/ring_pkg.sv
package ring_pkg;
    // Layout of the control word
    localparam int CFG_W         = 5;
    localparam int CFG_EN_BIT    = 0;
    localparam int CODE_W        = 4;
    localparam int CODE_LSB      = 1;
    // Smallest ring is 2**MIN_RING_LOG2 entries
    localparam int MIN_RING_LOG2 = 5;
    // Receive posting granule is 2**GRANULE_LOG2 descriptors
    localparam int GRANULE_LOG2  = 2;

    typedef logic [CODE_W-1:0] size_code_t;
endpackage

// File: rtl/ring_size_dec.sv
module ring_size_dec
    import ring_pkg::*;
#(
    parameter int IDX_W = 13
) (
    input  size_code_t       code,
    output logic [IDX_W-1:0] mask
);
    localparam int MAX_CODE = IDX_W - MIN_RING_LOG2;

    size_code_t clamped;

    always_comb begin
        clamped = (code > size_code_t'(MAX_CODE)) ? size_code_t'(MAX_CODE) : code;
        mask    = {IDX_W{1'b1}} >> (size_code_t'(MAX_CODE) - clamped);
    end
endmodule

// File: rtl/ring_kick_gate.sv
module ring_kick_gate
    import ring_pkg::*;
#(
    parameter bit RX_MODE = 1'b0
) (
    input  logic                    kick_we,
    input  logic [GRANULE_LOG2-1:0] kick_lsb,
    output logic                    accept,
    output logic                    reject
);
    // Receive flavour accepts only whole posting granules
    logic misaligned;

    always_comb begin
        misaligned = RX_MODE && (kick_lsb != '0);
        accept     = kick_we && !misaligned;
        reject     = kick_we && misaligned;
    end
endmodule

// File: rtl/ring_fetch_addr.sv
module ring_fetch_addr #(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 13,
    parameter int DESC_LOG2 = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  comp,
    output logic [ADDR_W-1:0] fetch_addr
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset     = ADDR_W'(comp) << DESC_LOG2;
        fetch_addr = base + offset;
    end
endmodule

// File: rtl/desc_ring_tracker.sv
module desc_ring_tracker
    import ring_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 13,
    parameter int ALIGN_W   = 11,
    parameter int DESC_LOG2 = 4,
    parameter bit RX_MODE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              kick_we,
    input  logic [IDX_W-1:0]  kick_wdata,
    input  logic              desc_done,
    output logic              ring_en,
    output logic [CODE_W-1:0] size_code,
    output logic [ADDR_W-1:0] base_addr,
    output logic [IDX_W-1:0]  kick_idx,
    output logic [IDX_W-1:0]  comp_idx,
    output logic [IDX_W-1:0]  pending,
    output logic              idle,
    output logic              kick_err,
    output logic [ADDR_W-1:0] fetch_addr
);
    localparam logic [ADDR_W-1:0] BASE_KEEP = ~((ADDR_W'(1) << ALIGN_W) - ADDR_W'(1));

    typedef struct packed {
        logic              en;
        size_code_t        code;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  kick;
        logic [IDX_W-1:0]  comp;
        logic              err;
    } ring_state_t;

    ring_state_t st_d, st_q;
    logic [IDX_W-1:0] size_mask;
    logic kick_ok, kick_bad;

    ring_size_dec #(.IDX_W(IDX_W)) u_size (
        .code (st_q.code),
        .mask (size_mask)
    );

    ring_kick_gate #(.RX_MODE(RX_MODE)) u_gate (
        .kick_we  (kick_we),
        .kick_lsb (kick_wdata[GRANULE_LOG2-1:0]),
        .accept   (kick_ok),
        .reject   (kick_bad)
    );

    ring_fetch_addr #(
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W),
        .DESC_LOG2 (DESC_LOG2)
    ) u_fetch (
        .base       (st_q.base),
        .comp       (st_q.comp),
        .fetch_addr (fetch_addr)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (cfg_we) begin
            st_d.en   = cfg_wdata[CFG_EN_BIT];
            st_d.code = cfg_wdata[CODE_LSB +: CODE_W];
            st_d.kick = '0;
            st_d.comp = '0;
        end else begin
            if (kick_ok) begin
                st_d.kick = kick_wdata & size_mask;
            end
            st_d.err = kick_bad;
            if (desc_done && st_q.en && (st_q.comp != st_q.kick)) begin
                st_d.comp = (st_q.comp + IDX_W'(1)) & size_mask;
            end
        end
        if (base_we) begin
            st_d.base = base_wdata & BASE_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ring_en   = st_q.en;
    assign size_code = st_q.code;
    assign base_addr = st_q.base;
    assign kick_idx  = st_q.kick;
    assign comp_idx  = st_q.comp;
    assign kick_err  = st_q.err;
    assign pending   = (st_q.kick - st_q.comp) & size_mask;
    assign idle      = st_q.en && (st_q.comp == st_q.kick);
endmodule

// File: rtl/ring_tracker_chk.sv
module ring_tracker_chk
    import ring_pkg::*;
#(
    parameter int IDX_W   = 13,
    parameter bit RX_MODE = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              kick_we,
    input logic [IDX_W-1:0]  kick_wdata,
    input logic              desc_done,
    input logic              ring_en,
    input logic [CODE_W-1:0] size_code,
    input logic [IDX_W-1:0]  kick_idx,
    input logic [IDX_W-1:0]  comp_idx,
    input logic [IDX_W-1:0]  pending,
    input logic              idle,
    input logic              kick_err
);
    localparam int TOP_CODE = IDX_W - MIN_RING_LOG2;

    logic [IDX_W-1:0] cmask;
    always_comb begin
        if (size_code >= CODE_W'(TOP_CODE)) cmask = {IDX_W{1'b1}};
        else cmask = IDX_W'((32'd1 << (MIN_RING_LOG2 + int'(size_code))) - 32'd1);
    end

    assert_index_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_idx <= cmask) && (kick_idx <= cmask));

    assert_cfg_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (kick_idx == '0) && (comp_idx == '0) && !kick_err);

    assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_done && ring_en && (comp_idx != kick_idx) && !cfg_we)
        |=> comp_idx == (($past(comp_idx) + IDX_W'(1)) & $past(cmask)));

    assert_comp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!desc_done && !cfg_we) |=> $stable(comp_idx));

    assert_rx_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (RX_MODE && kick_we && !cfg_we && (kick_wdata[1:0] != 2'b00))
        |=> kick_err && $stable(kick_idx));

    assert_idle_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (pending == '0) && ring_en);
endmodule

bind desc_ring_tracker ring_tracker_chk #(
    .IDX_W   (IDX_W),
    .RX_MODE (RX_MODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .kick_we    (kick_we),
    .kick_wdata (kick_wdata),
    .desc_done  (desc_done),
    .ring_en    (ring_en),
    .size_code  (size_code),
    .kick_idx   (kick_idx),
    .comp_idx   (comp_idx),
    .pending    (pending),
    .idle       (idle),
    .kick_err   (kick_err)
);

// File: tb/sim_desc_ring_tracker.sv
module sim_desc_ring_tracker;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 13;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic              cfg_we, base_we, kick_we, desc_done;
    logic [4:0]        cfg_wdata;
    logic [ADDR_W-1:0] base_wdata;
    logic [IDX_W-1:0]  kick_wdata;

    logic              en_o   [2];
    logic [3:0]        code_o [2];
    logic [ADDR_W-1:0] base_o [2];
    logic [IDX_W-1:0]  kick_o [2];
    logic [IDX_W-1:0]  comp_o [2];
    logic [IDX_W-1:0]  pend_o [2];
    logic              idle_o [2];
    logic              err_o  [2];
    logic [ADDR_W-1:0] fetch_o[2];

    desc_ring_tracker #(.RX_MODE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .base_we(base_we), .base_wdata(base_wdata), .kick_we(kick_we),
        .kick_wdata(kick_wdata), .desc_done(desc_done),
        .ring_en(en_o[0]), .size_code(code_o[0]), .base_addr(base_o[0]),
        .kick_idx(kick_o[0]), .comp_idx(comp_o[0]), .pending(pend_o[0]),
        .idle(idle_o[0]), .kick_err(err_o[0]), .fetch_addr(fetch_o[0]));

    desc_ring_tracker #(.RX_MODE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .base_we(base_we), .base_wdata(base_wdata), .kick_we(kick_we),
        .kick_wdata(kick_wdata), .desc_done(desc_done),
        .ring_en(en_o[1]), .size_code(code_o[1]), .base_addr(base_o[1]),
        .kick_idx(kick_o[1]), .comp_idx(comp_o[1]), .pending(pend_o[1]),
        .idle(idle_o[1]), .kick_err(err_o[1]), .fetch_addr(fetch_o[1]));

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // Reference state, shared control plus per-instance indices
    logic              m_en;
    logic [3:0]        m_code;
    logic [ADDR_W-1:0] m_base;
    logic [IDX_W-1:0]  m_kick[2];
    logic [IDX_W-1:0]  m_comp[2];
    logic              m_err[2];

    function automatic logic [IDX_W-1:0] ring_mask(logic [3:0] c);
        int sz;
        sz = (c >= 4'd8) ? 8192 : (32 << c);
        return IDX_W'(sz - 1);
    endfunction

    task automatic chk(string tag, int inst, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s inst%0d actual=%0h expected=%0h", tag, inst, act, exp);
        end
    endtask

    task automatic check_all(string ctx);
        for (int i = 0; i < 2; i++) begin
            logic [IDX_W-1:0] mk;
            mk = ring_mask(m_code);
            chk({ctx, " R2 enable"}, i, 64'(en_o[i]), 64'(m_en));
            chk({ctx, " R2 code"}, i, 64'(code_o[i]), 64'(m_code));
            chk({ctx, " R4 base"}, i, 64'(base_o[i]), 64'(m_base));
            chk({ctx, (i == 0) ? " R6 kick" : " R5 kick"}, i, 64'(kick_o[i]), 64'(m_kick[i]));
            chk({ctx, " R7 completion"}, i, 64'(comp_o[i]), 64'(m_comp[i]));
            chk({ctx, " R8 pending"}, i, 64'(pend_o[i]), 64'((m_kick[i] - m_comp[i]) & mk));
            chk({ctx, " R9 idle"}, i, 64'(idle_o[i]), 64'(m_en && (m_kick[i] == m_comp[i])));
            chk({ctx, " R6 err"}, i, 64'(err_o[i]), 64'(m_err[i]));
            chk({ctx, " R10 fetch"}, i, 64'(fetch_o[i]),
                64'(m_base + (ADDR_W'(m_comp[i]) << 4)));
        end
    endtask

    task automatic model_step();
        logic [IDX_W-1:0] mk;
        mk = ring_mask(m_code);
        for (int i = 0; i < 2; i++) begin
            logic [IDX_W-1:0] ok, oc;
            ok = m_kick[i];
            oc = m_comp[i];
            m_err[i] = 1'b0;
            if (cfg_we) begin
                m_kick[i] = '0;
                m_comp[i] = '0;
            end else begin
                if (kick_we) begin
                    if (i == 0 && kick_wdata[1:0] != 2'b00) m_err[i] = 1'b1;
                    else m_kick[i] = kick_wdata & mk;
                end
                if (desc_done && m_en && oc != ok) m_comp[i] = (oc + 1'b1) & mk;
            end
        end
        if (cfg_we) begin
            m_en   = cfg_wdata[0];
            m_code = cfg_wdata[4:1];
        end
        if (base_we) m_base = base_wdata & ~ADDR_W'(32'h7FF);
    endtask

    task automatic cyc(string ctx);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all(ctx);
        cfg_we = 0; base_we = 0; kick_we = 0; desc_done = 0;
    endtask

    task automatic do_cfg(bit en, logic [3:0] code, string ctx);
        cfg_we = 1; cfg_wdata = {code, en}; cyc(ctx);
    endtask

    task automatic do_kick(logic [IDX_W-1:0] v, string ctx);
        kick_we = 1; kick_wdata = v; cyc(ctx);
    endtask

    task automatic do_done(int n, string ctx);
        for (int k = 0; k < n; k++) begin
            desc_done = 1; cyc(ctx);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; cfg_we = 0; base_we = 0; kick_we = 0; desc_done = 0;
        cfg_wdata = '0; base_wdata = '0; kick_wdata = '0;
        m_en = 0; m_code = 0; m_base = 0;
        for (int i = 0; i < 2; i++) begin
            m_kick[i] = 0; m_comp[i] = 0; m_err[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1 reset");
        rst_n = 1;

        do_cfg(1'b1, 4'd0, "R2 enable 32");
        base_we = 1; base_wdata = 32'hDEAD_BEEF; cyc("R4 align");
        do_kick(13'd28, "R6 aligned kick");
        do_done(28, "R7 advance");
        do_done(1, "R7 idle done ignored");
        do_kick(13'd4, "R8 wrapped pending");
        do_done(8, "R3 wrap at 32");
        do_kick(13'd6, "R6 reject R5 accept");
        do_kick(13'd45, "R3 kick modulo 32");
        do_cfg(1'b1, 4'd12, "R3 clamp code");
        do_kick(13'h1FFC, "R3 top of 8192");
        do_done(3, "R7 big ring");
        cfg_we = 1; cfg_wdata = {4'd2, 1'b1}; kick_we = 1; kick_wdata = 13'd7;
        desc_done = 1; cyc("R11 control wins");
        do_kick(13'd8, "R5 kick 128");
        do_cfg(1'b0, 4'd2, "R2 disable");
        do_kick(13'd8, "R9 disabled kick");
        do_done(2, "R7 disabled done ignored");
        do_cfg(1'b1, 4'd1, "R2 enable 64");

        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom % 64);
            if (r == 0) begin
                cfg_we = 1;
                cfg_wdata = {4'($urandom % 16), ($urandom % 8) != 0};
            end
            if (r == 1) begin
                base_we = 1; base_wdata = $urandom;
            end
            if (($urandom % 5) == 0) begin
                kick_we = 1;
                kick_wdata = IDX_W'($urandom);
                if (($urandom % 2) == 0) kick_wdata[1:0] = 2'b00;
            end
            desc_done = ($urandom % 2) == 0;
            cyc("R7 R8 random");
        end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule